// File: doc/BRIEF.md
# DMA Parameter-Set Transfer Sequencer

This block walks a single DMA channel through one parameter set at a time. The active set holds a per-request byte count, an array count, a frame count, a sync mode and a link value. Every synchronization event makes the block issue one transfer request. The request is sized for the active sync mode and carries a flag that marks the last request of the set. The remaining counts are then stepped down.

When the last request of a set goes out, the block follows the link value. A link of all ones ends the chain and leaves the channel with an empty (null) set. Any other value selects a stored set in a small local table, which becomes the active set. This lets a chain alternate between two buffers. An event that finds a null set does not issue a request. It raises a sticky error, and the channel ignores all events until the error is cleared.

The table is filled through a write port. Software starts a chain by loading a table entry straight into the active set. Address generation, the bus transfer and completion reporting belong to other blocks.

Top module: `pset_sequencer`

## Requirements
- R1: After reset no request is pending (`req_valid_o`=0), `err_o`=0, and the active set is null. The first accepted event therefore raises the error. All table entries reset to null with an all-ones link.
- R2: In A mode (`mode`=0) a set with counts a, b, c produces b×c requests of a bytes each. Only the last one has `req_final_o`=1. After each request the array count drops by one. When the array count is 1, it instead reloads its starting value and the frame count drops by one.
- R3: In AB mode (`mode`=1) a set produces c requests of a×b bytes each. Only the request issued while the frame count is 1 has `req_final_o`=1.
- R4: When a final request is issued and the set's link is not all ones, the table entry selected by the low index bits of the link becomes the active set. The next event uses that entry's mode and counts.
- R5: When a final request is issued and the set's link is all ones, the active set becomes null. The next accepted event raises `err_o` and issues no request.
- R6: While `err_o`=1, events issue no request and change no counts. The error stays set until `err_clr_i` is high at a clock edge. An event in that same cycle is ignored. `start_i` does not clear the error.
- R7: While `req_valid_o`=1 and `req_ready_i`=0, the request bytes and final flag hold steady. An event in such a cycle is dropped and changes no counts.
- R8: `start_i` loads table entry `start_idx_i` into the active set. An event in the same cycle is ignored.
- R9: Writing a table entry does not change the active set until that entry is loaded by start or by a link.
- R10: A set that has any of its three counts equal to zero is null. An accepted event on it raises `err_o` and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Table write enable |
| cfg_idx_i | input | IDX_W | Table entry to write |
| cfg_acnt_i | input | A_W | Bytes per request unit |
| cfg_bcnt_i | input | B_W | Array count |
| cfg_ccnt_i | input | C_W | Frame count |
| cfg_mode_i | input | 1 | Sync mode: 0 = A, 1 = AB |
| cfg_link_i | input | LINK_W | Link value; all ones = null |
| start_i | input | 1 | Load entry `start_idx_i` as the active set |
| start_idx_i | input | IDX_W | Entry to load on start |
| evt_i | input | 1 | Synchronization event |
| err_clr_i | input | 1 | Clear the null-set error |
| req_valid_o | output | 1 | Transfer request pending |
| req_ready_i | input | 1 | Consumer takes the request |
| req_bytes_o | output | A_W+B_W | Byte count of the request |
| req_final_o | output | 1 | Request is the last of its set |
| err_o | output | 1 | Event hit a null set |

## Verification
Directed chains cover several cases. An A-mode set with array count above one shows the array-count reload, as distinct from a plain frame countdown. An AB-mode set linked from it shows both the product-sized request and the link reload. A null link, followed by events, clears and a further event, separates the terminating path from the linked one. Stalled handshakes, start-with-event and table writes during a run show which inputs are ignored. After that, seeded random traffic mixes modes, link targets, stalls, restarts and clears. Every cycle it is compared with a reference model built from the requirements.

// File: rtl/pset_pkg.sv
package pset_pkg;

    typedef enum logic {
        SYNC_A  = 1'b0,
        SYNC_AB = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/pset_store.sv
module pset_store #(
    parameter int A_W    = 16,
    parameter int B_W    = 16,
    parameter int C_W    = 16,
    parameter int LINK_W = 16,
    parameter int N_SETS = 4,
    parameter int IDX_W  = $clog2(N_SETS),
    parameter int N_RD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [A_W-1:0]    wr_acnt,
    input  logic [B_W-1:0]    wr_bcnt,
    input  logic [C_W-1:0]    wr_ccnt,
    input  logic              wr_mode,
    input  logic [LINK_W-1:0] wr_link,
    input  logic [IDX_W-1:0]  rd_idx  [N_RD],
    output logic [A_W-1:0]    rd_acnt [N_RD],
    output logic [B_W-1:0]    rd_bcnt [N_RD],
    output logic [C_W-1:0]    rd_ccnt [N_RD],
    output logic              rd_mode [N_RD],
    output logic [LINK_W-1:0] rd_link [N_RD]
);

    logic [A_W-1:0]    acnt_q [N_SETS];
    logic [B_W-1:0]    bcnt_q [N_SETS];
    logic [C_W-1:0]    ccnt_q [N_SETS];
    logic              mode_q [N_SETS];
    logic [LINK_W-1:0] link_q [N_SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SETS; i++) begin
                acnt_q[i] <= '0;
                bcnt_q[i] <= '0;
                ccnt_q[i] <= '0;
                mode_q[i] <= 1'b0;
                link_q[i] <= '1;
            end
        end else if (wr_en) begin
            acnt_q[wr_idx] <= wr_acnt;
            bcnt_q[wr_idx] <= wr_bcnt;
            ccnt_q[wr_idx] <= wr_ccnt;
            mode_q[wr_idx] <= wr_mode;
            link_q[wr_idx] <= wr_link;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_acnt[p] = acnt_q[rd_idx[p]];
        assign rd_bcnt[p] = bcnt_q[rd_idx[p]];
        assign rd_ccnt[p] = ccnt_q[rd_idx[p]];
        assign rd_mode[p] = mode_q[rd_idx[p]];
        assign rd_link[p] = link_q[rd_idx[p]];
    end

endmodule

// File: rtl/pset_step.sv
module pset_step
    import pset_pkg::*;
#(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int C_W = 16,
    parameter int BYTES_W = A_W + B_W
) (
    input  logic               mode,
    input  logic [A_W-1:0]     acnt,
    input  logic [B_W-1:0]     bcnt,
    input  logic [C_W-1:0]     ccnt,
    input  logic [B_W-1:0]     binit,
    output logic               is_null,
    output logic [BYTES_W-1:0] bytes,
    output logic               last,
    output logic [B_W-1:0]     bcnt_nx,
    output logic [C_W-1:0]     ccnt_nx
);

    logic b_one;
    logic c_one;

    always_comb begin
        b_one   = (bcnt == B_W'(1));
        c_one   = (ccnt == C_W'(1));
        is_null = (acnt == '0) || (bcnt == '0) || (ccnt == '0);
        bcnt_nx = bcnt;
        ccnt_nx = ccnt;
        if (sync_mode_e'(mode) == SYNC_AB) begin
            bytes   = BYTES_W'(acnt) * BYTES_W'(bcnt);
            last    = c_one;
            ccnt_nx = ccnt - C_W'(1);
        end else begin
            bytes = BYTES_W'(acnt);
            last  = b_one && c_one;
            if (b_one) begin
                bcnt_nx = binit;
                ccnt_nx = ccnt - C_W'(1);
            end else begin
                bcnt_nx = bcnt - B_W'(1);
            end
        end
    end

endmodule

// File: rtl/pset_sequencer.sv
module pset_sequencer
    import pset_pkg::*;
#(
    parameter int A_W    = 16,
    parameter int B_W    = 16,
    parameter int C_W    = 16,
    parameter int LINK_W = 16,
    parameter int N_SETS = 4,
    parameter int IDX_W  = $clog2(N_SETS),
    parameter int BYTES_W = A_W + B_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [A_W-1:0]     cfg_acnt_i,
    input  logic [B_W-1:0]     cfg_bcnt_i,
    input  logic [C_W-1:0]     cfg_ccnt_i,
    input  logic               cfg_mode_i,
    input  logic [LINK_W-1:0]  cfg_link_i,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   start_idx_i,
    input  logic               evt_i,
    input  logic               err_clr_i,
    output logic               req_valid_o,
    input  logic               req_ready_i,
    output logic [BYTES_W-1:0] req_bytes_o,
    output logic               req_final_o,
    output logic               err_o
);

    localparam int RD_START = 0;
    localparam int RD_LINK  = 1;
    localparam logic [LINK_W-1:0] NULL_LINK = '1;

    typedef struct packed {
        logic               valid;
        logic [BYTES_W-1:0] bytes;
        logic               last;
        logic               err;
        logic               mode;
        logic [A_W-1:0]     acnt;
        logic [B_W-1:0]     bcnt;
        logic [B_W-1:0]     binit;
        logic [C_W-1:0]     ccnt;
        logic [LINK_W-1:0]  link;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [IDX_W-1:0]  rd_idx  [2];
    logic [A_W-1:0]    rd_acnt [2];
    logic [B_W-1:0]    rd_bcnt [2];
    logic [C_W-1:0]    rd_ccnt [2];
    logic              rd_mode [2];
    logic [LINK_W-1:0] rd_link [2];

    logic               act_null;
    logic [BYTES_W-1:0] step_bytes;
    logic               step_last;
    logic [B_W-1:0]     step_bcnt;
    logic [C_W-1:0]     step_ccnt;
    logic               slot_free;
    logic               evt_take;
    logic               fire;
    logic               link_null;

    assign rd_idx[RD_START] = start_idx_i;
    assign rd_idx[RD_LINK]  = s_q.link[IDX_W-1:0];

    pset_store #(
        .A_W(A_W), .B_W(B_W), .C_W(C_W), .LINK_W(LINK_W),
        .N_SETS(N_SETS), .IDX_W(IDX_W), .N_RD(2)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we_i),
        .wr_idx  (cfg_idx_i),
        .wr_acnt (cfg_acnt_i),
        .wr_bcnt (cfg_bcnt_i),
        .wr_ccnt (cfg_ccnt_i),
        .wr_mode (cfg_mode_i),
        .wr_link (cfg_link_i),
        .rd_idx  (rd_idx),
        .rd_acnt (rd_acnt),
        .rd_bcnt (rd_bcnt),
        .rd_ccnt (rd_ccnt),
        .rd_mode (rd_mode),
        .rd_link (rd_link)
    );

    pset_step #(
        .A_W(A_W), .B_W(B_W), .C_W(C_W), .BYTES_W(BYTES_W)
    ) i_step (
        .mode    (s_q.mode),
        .acnt    (s_q.acnt),
        .bcnt    (s_q.bcnt),
        .ccnt    (s_q.ccnt),
        .binit   (s_q.binit),
        .is_null (act_null),
        .bytes   (step_bytes),
        .last    (step_last),
        .bcnt_nx (step_bcnt),
        .ccnt_nx (step_ccnt)
    );

    always_comb begin
        s_d       = s_q;
        slot_free = !s_q.valid || req_ready_i;
        link_null = (s_q.link == NULL_LINK);
        evt_take  = evt_i && !start_i && !err_clr_i && !s_q.err && slot_free;
        fire      = evt_take && !act_null;

        if (req_ready_i) begin
            s_d.valid = 1'b0;
        end

        if (start_i) begin
            s_d.mode  = rd_mode[RD_START];
            s_d.acnt  = rd_acnt[RD_START];
            s_d.bcnt  = rd_bcnt[RD_START];
            s_d.binit = rd_bcnt[RD_START];
            s_d.ccnt  = rd_ccnt[RD_START];
            s_d.link  = rd_link[RD_START];
        end else if (err_clr_i) begin
            s_d.err = 1'b0;
        end else if (evt_take) begin
            if (act_null) begin
                s_d.err = 1'b1;
            end else begin
                s_d.valid = 1'b1;
                s_d.bytes = step_bytes;
                s_d.last  = step_last;
                if (!step_last) begin
                    s_d.bcnt = step_bcnt;
                    s_d.ccnt = step_ccnt;
                end else if (link_null) begin
                    s_d.acnt  = '0;
                    s_d.bcnt  = '0;
                    s_d.binit = '0;
                    s_d.ccnt  = '0;
                end else begin
                    s_d.mode  = rd_mode[RD_LINK];
                    s_d.acnt  = rd_acnt[RD_LINK];
                    s_d.bcnt  = rd_bcnt[RD_LINK];
                    s_d.binit = rd_bcnt[RD_LINK];
                    s_d.ccnt  = rd_ccnt[RD_LINK];
                    s_d.link  = rd_link[RD_LINK];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mode  <= SYNC_A;
            s_q.link  <= NULL_LINK;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid_o = s_q.valid;
    assign req_bytes_o = s_q.bytes;
    assign req_final_o = s_q.last;
    assign err_o       = s_q.err;

    // R7: a stalled request holds its contents
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_bytes_o) && $stable(req_final_o)));

    // R6: no new request appears while the error is set
    p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !req_valid_o) |=> !req_valid_o);

    // R6: only a clear removes the error
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);

    // R5: a final request with a terminating link leaves a null set
    p_null_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && step_last && link_null) |=> act_null);

    // R10: an accepted event on a null set raises the error and no request
    p_null_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !start_i && !err_clr_i && !err_o && act_null && req_ready_i)
        |=> (err_o && !req_valid_o));

    // R2: the array count never exceeds its starting value
    p_bcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_null |-> (s_q.bcnt <= s_q.binit));

endmodule

// File: tb/test_pset_sequencer.sv
`timescale 1ns/1ps
module test_pset_sequencer;

    localparam int A_W = 16, B_W = 16, C_W = 16, LINK_W = 16, N_SETS = 4;
    localparam int IDX_W = 2, BYTES_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we_i = 1'b0;
    logic [IDX_W-1:0]   cfg_idx_i = '0;
    logic [A_W-1:0]     cfg_acnt_i = '0;
    logic [B_W-1:0]     cfg_bcnt_i = '0;
    logic [C_W-1:0]     cfg_ccnt_i = '0;
    logic               cfg_mode_i = 1'b0;
    logic [LINK_W-1:0]  cfg_link_i = '0;
    logic               start_i = 1'b0;
    logic [IDX_W-1:0]   start_idx_i = '0;
    logic               evt_i = 1'b0;
    logic               err_clr_i = 1'b0;
    logic               req_valid_o;
    logic               req_ready_i = 1'b1;
    logic [BYTES_W-1:0] req_bytes_o;
    logic               req_final_o;
    logic               err_o;

    always #5 clk = ~clk;

    pset_sequencer i_pset_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_acnt_i(cfg_acnt_i),
        .cfg_bcnt_i(cfg_bcnt_i), .cfg_ccnt_i(cfg_ccnt_i), .cfg_mode_i(cfg_mode_i),
        .cfg_link_i(cfg_link_i), .start_i(start_i), .start_idx_i(start_idx_i),
        .evt_i(evt_i), .err_clr_i(err_clr_i), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_bytes_o(req_bytes_o),
        .req_final_o(req_final_o), .err_o(err_o)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model
    bit      m_valid, m_final, m_err;
    longint  m_bytes;
    int      ma, mb, mc, mbi, mmode, mlink;
    int      sa[N_SETS], sb[N_SETS], sc[N_SETS], smode[N_SETS], slink[N_SETS];

    function automatic bit model_null();
        return (ma == 0) || (mb == 0) || (mc == 0);
    endfunction

    function automatic void model_load(int idx);
        ma = sa[idx]; mb = sb[idx]; mbi = sb[idx]; mc = sc[idx];
        mmode = smode[idx]; mlink = slink[idx];
    endfunction

    function automatic void model_update();
        bit free;
        bit last;
        free = !m_valid || req_ready_i;
        if (req_ready_i) m_valid = 1'b0;
        if (start_i) begin
            model_load(int'(start_idx_i));
        end else if (err_clr_i) begin
            m_err = 1'b0;
        end else if (evt_i && !m_err && free) begin
            if (model_null()) begin
                m_err = 1'b1;
            end else begin
                m_valid = 1'b1;
                m_bytes = (mmode == 1) ? longint'(ma) * longint'(mb) : longint'(ma);
                last    = (mmode == 1) ? (mc == 1) : (mb == 1 && mc == 1);
                m_final = last;
                if (last) begin
                    if (mlink == 'hFFFF) begin
                        ma = 0; mb = 0; mbi = 0; mc = 0;
                    end else begin
                        model_load(mlink % N_SETS);
                    end
                end else if (mmode == 1) begin
                    mc = mc - 1;
                end else if (mb == 1) begin
                    mb = mbi; mc = mc - 1;
                end else begin
                    mb = mb - 1;
                end
            end
        end
        if (cfg_we_i) begin
            sa[cfg_idx_i] = int'(cfg_acnt_i); sb[cfg_idx_i] = int'(cfg_bcnt_i);
            sc[cfg_idx_i] = int'(cfg_ccnt_i); smode[cfg_idx_i] = int'(cfg_mode_i);
            slink[cfg_idx_i] = int'(cfg_link_i);
        end
    endfunction

    task automatic check(string tag);
        n_checks++;
        if (req_valid_o !== m_valid || err_o !== m_err ||
            (m_valid && (longint'(req_bytes_o) !== m_bytes || req_final_o !== m_final))) begin
            n_fails++;
            $display("FAIL %s: valid=%0b err=%0b bytes=%0d final=%0b expected valid=%0b err=%0b bytes=%0d final=%0b",
                     tag, req_valid_o, err_o, req_bytes_o, req_final_o,
                     m_valid, m_err, m_bytes, m_final);
        end
    endtask

    task automatic idle();
        cfg_we_i = 1'b0; start_i = 1'b0; evt_i = 1'b0; err_clr_i = 1'b0; req_ready_i = 1'b1;
    endtask

    // inputs are driven before the call, at a falling edge
    task automatic cyc(string tag);
        model_update();
        @(posedge clk);
        #1;
        check(tag);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(int idx, int a, int b, int c, int mode, int link, string tag);
        cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_acnt_i = A_W'(a); cfg_bcnt_i = B_W'(b);
        cfg_ccnt_i = C_W'(c); cfg_mode_i = mode[0]; cfg_link_i = LINK_W'(link);
        cyc(tag);
    endtask

    task automatic start(int idx, string tag);
        start_i = 1'b1; start_idx_i = IDX_W'(idx);
        cyc(tag);
    endtask

    task automatic ev(string tag);
        evt_i = 1'b1;
        cyc(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_valid = 0; m_final = 0; m_err = 0; m_bytes = 0;
        ma = 0; mb = 0; mc = 0; mbi = 0; mmode = 0; mlink = 'hFFFF;
        for (int i = 0; i < N_SETS; i++) begin
            sa[i] = 0; sb[i] = 0; sc[i] = 0; smode[i] = 0; slink[i] = 'hFFFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 reset state");
        @(negedge clk);
        idle();

        ev("R1 event on reset set raises error");
        err_clr_i = 1'b1; cyc("R6 clear");

        wr(0, 4, 2, 3, 0, 1, "R2 write set0");
        wr(1, 3, 5, 2, 1, 'hFFFF, "R3 write set1");
        wr(2, 7, 0, 2, 0, 'hFFFF, "R10 write null set2");
        start(0, "R8 start set0");
        for (int i = 0; i < 6; i++) ev("R2 A-mode chain");
        ev("R4 linked AB set first");
        ev("R3 AB final");
        ev("R5 null link raises error");
        ev("R6 event while error");
        evt_i = 1'b1; err_clr_i = 1'b1; cyc("R6 clear with event");
        ev("R5 still null after clear");
        err_clr_i = 1'b1; cyc("R6 clear again");

        start(1, "R8 start set1");
        evt_i = 1'b1; req_ready_i = 1'b0; cyc("R7 request under stall");
        evt_i = 1'b1; req_ready_i = 1'b0; cyc("R7 event dropped while stalled");
        req_ready_i = 1'b0; cyc("R7 hold");
        cyc("R7 release");
        ev("R7 count unaffected by dropped event");

        start(0, "R8 start set0 again");
        start_i = 1'b1; start_idx_i = 2'd1; evt_i = 1'b1; cyc("R8 start beats event");
        ev("R9 first request from set1");
        wr(1, 9, 9, 9, 0, 'hFFFF, "R9 overwrite active entry");
        ev("R9 active set unchanged");

        start(2, "R10 start null set");
        ev("R10 event on zero count set");
        err_clr_i = 1'b1; cyc("R6 clear");

        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(99));
            if (r < 4) begin
                int link = ($urandom_range(3) == 0) ? 'hFFFF : int'($urandom_range(N_SETS - 1));
                cfg_we_i = 1'b1; cfg_idx_i = IDX_W'($urandom_range(N_SETS - 1));
                cfg_acnt_i = A_W'($urandom_range(5)); cfg_bcnt_i = B_W'($urandom_range(3, 1));
                cfg_ccnt_i = C_W'($urandom_range(3, 1)); cfg_mode_i = 1'($urandom_range(1));
                cfg_link_i = LINK_W'(link);
            end
            if (r >= 4 && r < 8) begin
                start_i = 1'b1; start_idx_i = IDX_W'($urandom_range(N_SETS - 1));
            end
            if (m_err && $urandom_range(4) == 0) err_clr_i = 1'b1;
            evt_i = ($urandom_range(1) == 1);
            req_ready_i = ($urandom_range(9) < 7);
            cyc("R2 R3 R4 R7 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule